// File: doc/BRIEF.md
# Keyed Watchdog with Early-Warning Timer

This peripheral holds two down-counters behind a small byte-wide register bus. Both are paced by a 32.768 kHz tick input, either directly or through a shared rate selector. The early-warning counter runs periodically. Each time it expires it raises a one-cycle interrupt pulse, reloads and carries on. The watchdog counter is one-shot. Once it is started, it must be restarted by a write of the exact key byte before it runs out. If it runs out, a reset request is raised and held until the block itself is reset.

Software sets up the rates and count values first. It then starts the watchdog by setting the run/lock bit in the configuration register. Separate lock bits freeze the configuration, the rate selector, the warning count and the watchdog count against later writes. A stop-mode pair in the control register lets a debugger or a sleep sequence pause the watchdog without losing its count.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset every readable register returns 0x00, and both warn_irq and wdt_rst are low.
- R2: Register offsets are as follows:
  - 0x01: configuration, bits 5:0.
  - 0x02: rate select, bits 1:0.
  - 0x03 and 0x04: warning count high and low.
  - 0x05: control, bits 5:4.
  - 0x06 and 0x09: watchdog count low and high.
  - 0x07: key.
  A high count byte stores only its CNT_W-8 low bits. Reads return the stored contents zero-extended. The key register, control bit 0 and all unmapped offsets read as 0.
- R3: Each configuration lock bit makes writes to its target register(s) ignored:
  - bit 0 locks the configuration register.
  - bit 1 locks the rate select.
  - bit 2 locks both warning count bytes.
  - bit 3 locks both watchdog count bytes.
- R4: A control write with bit 0 set loads the warning counter from its count value N. After N paced ticks warn_irq is high for exactly one clock, and the pulse then repeats every N paced ticks. With N = 0 the counter stays idle and never pulses.
- R5: Rate select 0 paces at every tick, 1 at every DIV_MID-th tick and 2 or 3 at every DIV_SLOW-th tick. The dividers count raw ticks from reset. The warning counter always uses the selected pace.
- R6: A configuration write that changes bit 3 from 0 to 1 loads the watchdog counter and starts it. wdt_rst rises after N watchdog ticks, with N = 0 acting as 1. Watchdog ticks are raw ticks when configuration bit 4 is 0 and the selected pace when it is 1.
- R7: While the watchdog runs and configuration bit 5 is 1, writing 0x5C to the key register reloads the watchdog counter. Any other key byte, or any key write while bit 5 is 0, has no effect.
- R8: With control bit 4 set, setting control bit 5 freezes the watchdog count and clearing it resumes counting. Control bit 5 alone does not freeze it.
- R9: Clearing configuration bit 3 stops the watchdog, which then never raises wdt_rst. It also unlocks the watchdog count bytes.
- R10: wdt_rst stays high from the clock after expiry until rst_n is asserted, regardless of ticks or key writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tick_32k | input | 1 | One-clock pulse per 32.768 kHz period |
| warn_irq | output | 1 | One-clock early-warning pulse |
| wdt_rst | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with CNT_W = 10, DIV_MID = 4 and DIV_SLOW = 16. With these values a 2-bit high count byte exercises the partial-width readback. The divided paces also expire within a few dozen raw ticks, so every rate selection can be timed to the exact tick. Expiry is swept over small count values for both counters, and each expected tick number is computed arithmetically from N and the divider. Because the dividers start from reset, the prescaled watchdog and warning expiry points are exact rather than phase-dependent.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   localparam int unsigned REG_CFG     = 1;
   localparam int unsigned REG_RATE    = 2;
   localparam int unsigned REG_WARN_HI = 3;
   localparam int unsigned REG_WARN_LO = 4;
   localparam int unsigned REG_CTRL    = 5;
   localparam int unsigned REG_WD_LO   = 6;
   localparam int unsigned REG_KEY     = 7;
   localparam int unsigned REG_WD_HI   = 9;

   localparam logic [7:0] KICK_KEY = 8'h5C;

   // bit5 .. bit0 of the configuration register
   typedef struct packed {
      logic kick_en;
      logic wd_scaled;
      logic wd_lock;
      logic warn_lock;
      logic rate_lock;
      logic cfg_lock;
   } cfg_t;

   typedef enum logic [1:0] {
      RATE_FULL     = 2'd0,
      RATE_MID      = 2'd1,
      RATE_SLOW     = 2'd2,
      RATE_SLOW_ALT = 2'd3
   } rate_e;

   // bit5 .. bit4 of the control register
   typedef struct packed {
      logic halt_req;
      logic halt_mode;
   } ctrl_t;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/kwd_divider.sv
module kwd_divider #(
   parameter int unsigned DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_out
);
   localparam int unsigned CW = (DIV < 2) ? 1 : $clog2(DIV);

   logic [CW-1:0] cnt_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("kwd_divider: DIV must be at least 2");
      end

      if (kwd_pkg::is_pow2(DIV)) begin : g_pow2
         assign tick_out = tick_in & (&cnt_q);
         always_ff @(posedge clk) begin
            if (!rst_n)       cnt_q <= '0;
            else if (tick_in) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_modulo
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         assign tick_out = tick_in & (cnt_q == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n)       cnt_q <= '0;
            else if (tick_in) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int unsigned DIV_MID  = 32,
   parameter int unsigned DIV_SLOW = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_raw,
   input  kwd_pkg::rate_e rate_sel,
   output logic          tick_out
);
   import kwd_pkg::*;

   localparam int unsigned N_DIV = 2;
   localparam int unsigned DIVS [N_DIV] = '{DIV_MID, DIV_SLOW};

   logic [N_DIV:0] taps;
   assign taps[0] = tick_raw;

   generate
      if (DIV_SLOW <= DIV_MID) begin : g_bad_order
         $error("kwd_prescaler: DIV_SLOW must exceed DIV_MID");
      end

      for (genvar g = 0; g < N_DIV; g++) begin : g_div
         kwd_divider #(.DIV(DIVS[g])) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_in  (tick_raw),
            .tick_out (taps[g+1])
         );
      end
   endgenerate

   always_comb begin
      case (rate_sel)
         RATE_FULL: tick_out = taps[0];
         RATE_MID:  tick_out = taps[1];
         default:   tick_out = taps[2];
      endcase
   end

endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          PERIODIC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             run,
   output logic             fire,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wrap_val;
   logic             at_one;
   logic             at_zero;
   logic             expiring;

   assign at_one  = (cnt_q == CNT_W'(1));
   assign at_zero = (cnt_q == '0);

   generate
      if (PERIODIC) begin : g_periodic
         // zero means idle: no pulse until software loads a value
         assign expiring = at_one;
         assign wrap_val = load_val;
      end else begin : g_oneshot
         // zero behaves like one so a started counter always expires
         assign expiring = at_one | at_zero;
         assign wrap_val = '0;
      end
   endgenerate

   assign fire = !load && run && tick && expiring;
   assign cnt  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && tick) begin
         if (expiring)      cnt_q <= wrap_val;
         else if (!at_zero) cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/kwd_regs.sv
module kwd_regs #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output kwd_pkg::cfg_t     cfg,
   output kwd_pkg::rate_e    rate,
   output kwd_pkg::ctrl_t    ctrl,
   output logic [CNT_W-1:0]  warn_val,
   output logic [CNT_W-1:0]  wd_val,
   output logic              warn_reload,
   output logic              wd_start,
   output logic              wd_kick
);
   import kwd_pkg::*;

   localparam int unsigned HI_W = CNT_W - 8;

   cfg_t             cfg_q;
   rate_e            rate_q;
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] warn_q;
   logic [CNT_W-1:0] wd_q;

   logic w_cfg, w_rate, w_whi, w_wlo, w_ctrl, w_dlo, w_dhi, w_key;

   assign w_cfg  = bus_wr && (bus_addr == ADDR_W'(REG_CFG));
   assign w_rate = bus_wr && (bus_addr == ADDR_W'(REG_RATE));
   assign w_whi  = bus_wr && (bus_addr == ADDR_W'(REG_WARN_HI));
   assign w_wlo  = bus_wr && (bus_addr == ADDR_W'(REG_WARN_LO));
   assign w_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign w_dlo  = bus_wr && (bus_addr == ADDR_W'(REG_WD_LO));
   assign w_dhi  = bus_wr && (bus_addr == ADDR_W'(REG_WD_HI));
   assign w_key  = bus_wr && (bus_addr == ADDR_W'(REG_KEY));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         rate_q <= RATE_FULL;
         ctrl_q <= '0;
         warn_q <= '0;
         wd_q   <= '0;
      end else begin
         if (w_cfg && !cfg_q.cfg_lock)    cfg_q  <= cfg_t'(bus_wdata[5:0]);
         if (w_rate && !cfg_q.rate_lock)  rate_q <= rate_e'(bus_wdata[1:0]);
         if (w_whi && !cfg_q.warn_lock)   warn_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
         if (w_wlo && !cfg_q.warn_lock)   warn_q[7:0] <= bus_wdata;
         if (w_dhi && !cfg_q.wd_lock)     wd_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
         if (w_dlo && !cfg_q.wd_lock)     wd_q[7:0] <= bus_wdata;
         if (w_ctrl)                      ctrl_q <= ctrl_t'(bus_wdata[5:4]);
      end
   end

   // action strobes act at the same edge as the bus write
   assign warn_reload = w_ctrl && bus_wdata[0];
   assign wd_start    = w_cfg && !cfg_q.cfg_lock && bus_wdata[3] && !cfg_q.wd_lock;
   assign wd_kick     = w_key && (bus_wdata == KICK_KEY) && cfg_q.kick_en && cfg_q.wd_lock;

   always_comb begin
      case (bus_addr)
         ADDR_W'(REG_CFG):     bus_rdata = {2'b00, cfg_q};
         ADDR_W'(REG_RATE):    bus_rdata = {6'b0, rate_q};
         ADDR_W'(REG_WARN_HI): bus_rdata = 8'(warn_q[CNT_W-1:8]);
         ADDR_W'(REG_WARN_LO): bus_rdata = warn_q[7:0];
         ADDR_W'(REG_CTRL):    bus_rdata = {2'b00, ctrl_q, 4'b0000};
         ADDR_W'(REG_WD_LO):   bus_rdata = wd_q[7:0];
         ADDR_W'(REG_WD_HI):   bus_rdata = 8'(wd_q[CNT_W-1:8]);
         default:              bus_rdata = 8'h00;
      endcase
   end

   assign cfg      = cfg_q;
   assign rate     = rate_q;
   assign ctrl     = ctrl_q;
   assign warn_val = warn_q;
   assign wd_val   = wd_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DIV_MID  = 32,
   parameter int unsigned DIV_SLOW = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              tick_32k,
   output logic              warn_irq,
   output logic              wdt_rst
);
   import kwd_pkg::*;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("keyed_watchdog: ADDR_W must reach offset 9");
      end
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
         $error("keyed_watchdog: CNT_W must be 9..16");
      end
   endgenerate

   cfg_t             cfg_w;
   rate_e            rate_w;
   ctrl_t            ctrl_w;
   logic [CNT_W-1:0] warn_val, wd_val, warn_cnt, wd_cnt;
   logic             warn_reload, wd_start, wd_kick, wd_load;
   logic             tick_sel, wd_tick, wd_halted, wd_run;
   logic             warn_fire, wd_fire;
   logic             warn_irq_q, wdt_rst_q;

   kwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .cfg         (cfg_w),
      .rate        (rate_w),
      .ctrl        (ctrl_w),
      .warn_val    (warn_val),
      .wd_val      (wd_val),
      .warn_reload (warn_reload),
      .wd_start    (wd_start),
      .wd_kick     (wd_kick)
   );

   kwd_prescaler #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_raw (tick_32k),
      .rate_sel (rate_w),
      .tick_out (tick_sel)
   );

   kwd_countdown #(.CNT_W(CNT_W), .PERIODIC(1'b1)) u_warn (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (warn_reload),
      .load_val (warn_val),
      .tick     (tick_sel),
      .run      (1'b1),
      .fire     (warn_fire),
      .cnt      (warn_cnt)
   );

   assign wd_tick   = cfg_w.wd_scaled ? tick_sel : tick_32k;
   assign wd_halted = ctrl_w.halt_mode && ctrl_w.halt_req;
   assign wd_run    = cfg_w.wd_lock && !wd_halted && !wdt_rst_q;
   assign wd_load   = wd_start || wd_kick;

   kwd_countdown #(.CNT_W(CNT_W), .PERIODIC(1'b0)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wd_load),
      .load_val (wd_val),
      .tick     (wd_tick),
      .run      (wd_run),
      .fire     (wd_fire),
      .cnt      (wd_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         warn_irq_q <= 1'b0;
         wdt_rst_q  <= 1'b0;
      end else begin
         warn_irq_q <= warn_fire;
         wdt_rst_q  <= wdt_rst_q | wd_fire;
      end
   end

   assign warn_irq = warn_irq_q;
   assign wdt_rst  = wdt_rst_q;

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_32k,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              warn_irq,
   input logic              wdt_rst,
   input logic [5:0]        cfg_bits,
   input logic [CNT_W-1:0]  wd_cnt,
   input logic              wd_load,
   input logic              halted
);
   import kwd_pkg::*;

   // R4: a warning pulse follows a tick edge
   a_r4_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      warn_irq |-> $past(tick_32k));

   // R10: reset request is sticky
   a_r10_rst_holds: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> wdt_rst);

   // R6: expiry only happens at a tick
   a_r6_rst_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> $past(tick_32k));

   // R9: a stopped watchdog never raises the reset request
   a_r9_idle_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bits[3] && !wdt_rst) |=> !wdt_rst);

   // R8: halted watchdog keeps its count
   a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !wd_load) |=> $stable(wd_cnt));

   // R3: locked configuration ignores writes
   a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(REG_CFG) && cfg_bits[0]) |=> $stable(cfg_bits));

   // R2: key register reads as zero
   a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(REG_KEY)) |-> (bus_rdata == 8'h00));

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_32k  (tick_32k),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .warn_irq  (warn_irq),
   .wdt_rst   (wdt_rst),
   .cfg_bits  (cfg_w),
   .wd_cnt    (wd_cnt),
   .wd_load   (wd_load),
   .halted    (wd_halted)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;

   localparam int unsigned AW = 5;
   localparam int unsigned CW = 10;
   localparam int unsigned DM = 4;
   localparam int unsigned DS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          tick_32k = 1'b0;
   logic          warn_irq;
   logic          wdt_rst;

   int n_checks = 0;
   int n_fail   = 0;
   int irq_total = 0;
   int irq_extra = 0;

   always #2 clk = ~clk;

   keyed_watchdog #(.ADDR_W(AW), .CNT_W(CW), .DIV_MID(DM), .DIV_SLOW(DS)) u_keyed_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_32k  (tick_32k),
      .warn_irq  (warn_irq),
      .wdt_rst   (wdt_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_32k = 1'b0; bus_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      irq_total = 0;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_addr = AW'(a);
      #1 d = int'(bus_rdata);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_32k = 1'b1;
         @(negedge clk) tick_32k = 1'b0;
         if (warn_irq) irq_total++;
         @(negedge clk);
         if (warn_irq) irq_extra++;
      end
   endtask

   task automatic rd_check(input string req, input int a, input int exp);
      int v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      for (int a = 0; a < 16; a++) rd_check("R1 reset readback", a, 0);
      check("R1 warn_irq low", int'(warn_irq), 0);
      check("R1 wdt_rst low", int'(wdt_rst), 0);

      // R2: map, partial high byte, write-only and unmapped reads
      wr(1, 8'h30); rd_check("R2 cfg", 1, 8'h30);
      wr(2, 8'h02); rd_check("R2 rate", 2, 8'h02);
      wr(3, 8'hFF); rd_check("R2 warn hi 2 bits", 3, 8'h03);
      wr(4, 8'hA5); rd_check("R2 warn lo", 4, 8'hA5);
      wr(5, 8'h31); rd_check("R2 ctrl bit0 reads 0", 5, 8'h30);
      wr(6, 8'h5A); rd_check("R2 wd lo", 6, 8'h5A);
      wr(9, 8'hFD); rd_check("R2 wd hi 2 bits", 9, 8'h01);
      wr(7, 8'h12); rd_check("R2 key reads 0", 7, 0);
      rd_check("R2 unmapped 0x08", 8, 0);
      rd_check("R2 unmapped 0x00", 0, 0);

      // R3: lock bits
      do_reset();
      wr(2, 1); wr(4, 8'h11); wr(6, 8'h22);
      wr(1, 8'h0E);
      wr(2, 2);     rd_check("R3 rate locked", 2, 1);
      wr(4, 8'h33); rd_check("R3 warn lo locked", 4, 8'h11);
      wr(3, 8'h01); rd_check("R3 warn hi locked", 3, 0);
      wr(6, 8'h44); rd_check("R3 wd lo locked", 6, 8'h22);
      wr(1, 8'h0F); wr(1, 8'h00); rd_check("R3 cfg locked", 1, 8'h0F);

      // R4: warning period sweep at full rate
      for (int n = 1; n <= 5; n++) begin
         do_reset();
         wr(4, n); wr(5, 1);
         tick(n - 1); check($sformatf("R4 no pulse before %0d ticks", n), irq_total, 0);
         tick(1);     check($sformatf("R4 first pulse N=%0d", n), irq_total, 1);
         tick(n);     check($sformatf("R4 periodic pulse N=%0d", n), irq_total, 2);
      end
      do_reset();
      wr(4, 0); wr(5, 1); tick(20);
      check("R4 zero count idle", irq_total, 0);
      check("R4 pulse one clock wide", irq_extra, 0);

      // R5: prescaled warning rates
      do_reset();
      wr(2, 1); wr(4, 3); wr(5, 1);
      tick(3*DM - 1); check("R5 mid rate early", irq_total, 0);
      tick(1);        check("R5 mid rate expiry", irq_total, 1);
      do_reset();
      wr(2, 2); wr(4, 2); wr(5, 1);
      tick(2*DS - 1); check("R5 slow rate early", irq_total, 0);
      tick(1);        check("R5 slow rate expiry", irq_total, 1);
      do_reset();
      wr(2, 3); wr(4, 1); wr(5, 1);
      tick(DS - 1);   check("R5 code 3 early", irq_total, 0);
      tick(1);        check("R5 code 3 expiry", irq_total, 1);

      // R6: watchdog expiry sweep, raw ticks
      for (int n = 1; n <= 6; n++) begin
         do_reset();
         wr(6, n); wr(1, 8'h08);
         tick(n - 1); check($sformatf("R6 no reset before %0d ticks", n), int'(wdt_rst), 0);
         tick(1);     check($sformatf("R6 reset at N=%0d", n), int'(wdt_rst), 1);
      end
      do_reset();
      wr(6, 0); wr(1, 8'h08);
      check("R6 zero count not yet", int'(wdt_rst), 0);
      tick(1); check("R6 zero count acts as one", int'(wdt_rst), 1);
      do_reset();
      wr(2, 1); wr(6, 2); wr(1, 8'h18);
      tick(2*DM - 1); check("R6 prescaled early", int'(wdt_rst), 0);
      tick(1);        check("R6 prescaled expiry", int'(wdt_rst), 1);

      // R7: key restart
      do_reset();
      wr(6, 4); wr(1, 8'h28);
      tick(3); wr(7, 8'h5C);
      tick(3); check("R7 kick reloaded", int'(wdt_rst), 0);
      wr(7, 8'h5D);
      tick(1); check("R7 wrong key ignored", int'(wdt_rst), 1);
      do_reset();
      wr(6, 4); wr(1, 8'h08);
      tick(3); wr(7, 8'h5C);
      tick(1); check("R7 key disabled ignored", int'(wdt_rst), 1);

      // R8: stop mode
      do_reset();
      wr(6, 4); wr(5, 8'h10); wr(1, 8'h08);
      tick(2); wr(5, 8'h30);
      tick(10); check("R8 halted no reset", int'(wdt_rst), 0);
      wr(5, 8'h10);
      tick(1); check("R8 resumed count kept", int'(wdt_rst), 0);
      tick(1); check("R8 resumed expiry", int'(wdt_rst), 1);
      do_reset();
      wr(6, 3); wr(5, 8'h20); wr(1, 8'h08);
      tick(3); check("R8 bit5 alone no halt", int'(wdt_rst), 1);

      // R9: stopping the watchdog
      do_reset();
      wr(6, 3); wr(1, 8'h08);
      tick(2); wr(1, 8'h00);
      tick(10); check("R9 stopped no reset", int'(wdt_rst), 0);
      wr(6, 8'h07); rd_check("R9 count unlocked", 6, 8'h07);

      // R10: sticky reset request
      do_reset();
      wr(6, 1); wr(1, 8'h28);
      tick(1); check("R10 expired", int'(wdt_rst), 1);
      wr(7, 8'h5C); tick(5);
      check("R10 still high", int'(wdt_rst), 1);
      do_reset();
      check("R10 cleared by reset", int'(wdt_rst), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule